// File: doc/BRIEF.md
# DRAM Refresh Request Sequencer

This block keeps a dynamic RAM refreshed by borrowing the bus for one short cycle at a time. An interval timer produces an active-low pulse roughly every 15 µs. The sequencer catches the falling edge of that pulse in a request flip-flop. The flip-flop drives a request on the highest-priority DMA channel, channel 0.

When the bus arbiter grants the request, the sequencer owns the bus. While it does, the processor is held off and its address and data buffers float. For one cycle the sequencer presents the current row address with the row strobe asserted. It then advances its row counter, signals that the bus is being handed back, and goes idle.

Each timer pulse refreshes one row, and the counter wraps after the last row. With 256 rows and a 15 µs pulse, every row is refreshed within 4 ms. The grant is accepted only while a request is pending. A second pulse that arrives before the grant does not queue a second request.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, dreq, ras, bus_own and bus_release are 0 and row_addr is 0.
- R2: A high-to-low transition of tick_n, sampled at a clock edge, makes dreq 1 from that edge on until the request is granted.
- R3: If grant is 1 at an edge while dreq is 1 and the block is idle, then in the following cycle ras is 1 for exactly one cycle, dreq is 0, bus_own is 1, and row_addr shows the row counter value from before the refresh.
- R4: In the cycle right after the ras cycle, bus_release is 1 for one cycle, bus_own is still 1 and row_addr equals the previous row plus one. In the cycle after that, bus_own is 0.
- R5: The row counter is ROW_W bits wide (8 by default). From 255 it wraps to 0.
- R6: A second falling edge of tick_n while a request is still pending does not queue a second request. After that single refresh, dreq stays 0.
- R7: grant while no request is pending is ignored. ras and bus_release stay 0, and row_addr does not change.
- R8: Holding tick_n low after a refresh does not raise a new request. Only a fresh high-to-low transition does.
- R9: 256 consecutive refreshes visit each of the 256 row addresses once and end at the starting row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_n | input | 1 | Active-low refresh pulse from the interval timer |
| grant | input | 1 | Bus grant for the refresh channel |
| dreq | output | 1 | Refresh request on the highest-priority channel |
| row_addr | output | ROW_W | Row address to refresh |
| ras | output | 1 | Row strobe, high for the one refresh cycle |
| bus_own | output | 1 | High while the sequencer holds the bus (processor held off, buffers floated) |
| bus_release | output | 1 | One-cycle pulse as the bus is handed back |

## Verification
The main refresh sequence is tried in several ways:
- with grants arriving at once and after waits of up to several cycles, which separates accepting the pending request from reacting to the pulse itself;
- with a doubled timer pulse before the grant, which tells a non-queuing request flag from a counting one;
- with grant held high past the refresh, which exposes a grant wrongly accepted without a request.

A long run of back-to-back refreshes tracks every row address, to show the counter steps by one and wraps. A pulse held low across a refresh shows that requests come from edges and not from levels.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_n,
  input  logic             grant,
  output logic             dreq,
  output logic [ROW_W-1:0] row_addr,
  output logic             ras,
  output logic             bus_own,
  output logic             bus_release
);
  localparam logic [ROW_W-1:0] ROW_STEP = 1;

  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_HANDBACK} seq_t;

  seq_t             state;
  logic             tick_q;
  logic             pend;
  logic [ROW_W-1:0] row;
  logic             fall;
  logic             take;

  assign fall = tick_q & ~tick_n;
  assign take = (state == S_IDLE) & pend & grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= 1'b1;
      pend   <= 1'b0;
      row    <= '0;
      state  <= S_IDLE;
    end else begin
      tick_q <= tick_n;
      pend   <= fall | (pend & ~take);
      case (state)
        S_IDLE:     if (take) state <= S_STROBE;
        S_STROBE: begin
          state <= S_HANDBACK;
          row   <= row + ROW_STEP;
        end
        S_HANDBACK: state <= S_IDLE;
        default:    state <= S_IDLE;
      endcase
    end
  end

  assign dreq        = pend;
  assign row_addr    = row;
  assign ras         = (state == S_STROBE);
  assign bus_own     = (state != S_IDLE);
  assign bus_release = (state == S_HANDBACK);
endmodule

// File: rtl/refresh_seq_checker.sv
module refresh_seq_checker #(
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             grant,
  input logic             dreq,
  input logic [ROW_W-1:0] row_addr,
  input logic             ras,
  input logic             bus_own,
  input logic             bus_release
);
  localparam logic [ROW_W-1:0] ONE = 1;

  AST_RAS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ras |=> !ras); // R3
  AST_RAS_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras) |-> ($past(grant) && $past(dreq))); // R3
  AST_RAS_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ras |-> bus_own); // R3
  AST_RELEASE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ras |=> (bus_release && bus_own)); // R4
  AST_BUS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |=> !bus_own); // R4
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_release) |-> (row_addr == $past(row_addr) + ONE)); // R5
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(bus_release) |-> $stable(row_addr)); // R7
endmodule

bind dram_refresh_seq refresh_seq_checker #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .dreq(dreq), .row_addr(row_addr),
  .ras(ras), .bus_own(bus_own), .bus_release(bus_release)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_n = 1'b1;
  logic       grant = 1'b0;
  logic       dreq, ras, bus_own, bus_release;
  logic [7:0] row_addr;

  int         n_run = 0;
  int         n_fail = 0;
  logic [7:0] model_row = 8'd0;

  always #2 clk = ~clk;

  dram_refresh_seq #(.ROW_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick_n(tick_n), .grant(grant), .dreq(dreq),
    .row_addr(row_addr), .ras(ras), .bus_own(bus_own), .bus_release(bus_release)
  );

  // {grant delay[3:0], double pulse, grant held past refresh}
  localparam logic [5:0] VEC [8] = '{
    {4'd0, 1'b0, 1'b0}, {4'd3, 1'b0, 1'b0}, {4'd1, 1'b1, 1'b0}, {4'd0, 1'b0, 1'b1},
    {4'd7, 1'b1, 1'b0}, {4'd2, 1'b0, 1'b1}, {4'd5, 1'b1, 1'b1}, {4'd0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) tick_n = 1'b0;
    @(negedge clk) tick_n = 1'b1;
  endtask

  task automatic service(input int dly, input bit dbl, input bit hold, input bit full);
    pulse();
    if (full) check("R2 dreq after falling edge", dreq, 1);
    if (dbl) pulse();
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      if (full) check("R2 dreq held while pending", dreq, 1);
    end
    grant = 1'b1;
    @(negedge clk);
    if (!hold) grant = 1'b0;
    check("R3 ras", ras, 1);
    if (full) begin
      check("R3 dreq cleared", dreq, 0);
      check("R3 bus_own", bus_own, 1);
      check("R3 row_addr", row_addr, model_row);
    end
    model_row = model_row + 8'd1;
    @(negedge clk);
    check("R4 bus_release", bus_release, 1);
    check("R5 row step", row_addr, model_row);
    if (full) begin
      check("R4 ras single", ras, 0);
      check("R4 bus_own in handback", bus_own, 1);
    end
    @(negedge clk);
    grant = 1'b0;
    if (full) begin
      check("R4 bus_own dropped", bus_own, 0);
      check("R6 no queued request", dreq, 0);
      check("R7 held grant ignored", ras, 0);
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] seen;
    logic [7:0]   start;
    repeat (3) @(negedge clk);
    check("R1 dreq reset", dreq, 0);
    check("R1 ras reset", ras, 0);
    check("R1 bus_own reset", bus_own, 0);
    check("R1 row reset", row_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bus_release after reset", bus_release, 0);

    foreach (VEC[k])
      service(int'(VEC[k][5:2]), VEC[k][1], VEC[k][0], 1'b1);

    grant = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 lone grant ras", ras, 0);
      check("R7 lone grant release", bus_release, 0);
    end
    grant = 1'b0;
    check("R7 row unchanged", row_addr, model_row);

    @(negedge clk) tick_n = 1'b0;
    @(negedge clk);
    grant = 1'b1;
    @(negedge clk) grant = 1'b0;
    check("R8 ras from held pulse", ras, 1);
    model_row = model_row + 8'd1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R8 no retrigger on low level", dreq, 0);
    end
    tick_n = 1'b1;
    @(negedge clk);
    check("R8 rising edge no request", dreq, 0);

    seen = '0;
    start = row_addr;
    for (int i = 0; i < 256; i++) begin
      seen[row_addr] = 1'b1;
      service(0, 1'b0, 1'b0, 1'b0);
    end
    check("R9 all rows visited", {31'd0, &seen}, 1);
    check("R9 back at start", row_addr, start);

    while (row_addr != 8'd255) service(0, 1'b0, 1'b0, 1'b0);
    service(1, 1'b0, 1'b0, 1'b1);
    check("R5 wrap to zero", row_addr, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule